// File: doc/BRIEF.md
# USB PHY Power Sequencer

This block brings a high-speed USB PHY up and down by stepping three control outputs (PLL reset, suspend-mode and connect) in a fixed order. A single-cycle power-up or power-down command starts a sequence. The PHY mode on `mode_sel_i` is captured when the command is accepted. While the sequence runs the block reports busy. At the end it pulses done, and it raises a timeout flag if the PLL never reported lock.

Time is counted in microsecond ticks. A clock divider makes them, and `CLK_PER_US` sets how many clock cycles make one microsecond. The `ALT_PROFILE` parameter picks one of two sequencing profiles. The main profile polls the PLL lock input and closes the connection once lock is seen. It acts only when the high-speed function mode is selected. The alternate profile does not poll. It waits a fixed settle delay instead, and it drives suspend-mode only in the high-speed USB 2.0 mode.

Top module: `usbphy_pwr_seq`

## Requirements
- R1: After reset, `pll_rst_o` is 1, and `suspm_o`, `connect_o`, `busy_o`, `done_o` and `timeout_o` are all 0.
- R2: In the main profile, a power-up with mode 3 first clears `pll_rst_o`. It sets `suspm_o` on a later cycle. Only after that does it start sampling `pll_lock_i`, once per microsecond tick.
- R3: In the main profile, when lock is sampled high during polling, `connect_o` is set, `done_o` pulses and `timeout_o` stays 0.
- R4: In the main profile, if lock is not seen in `POLL_MAX` polls spaced one tick apart, the sequence ends with `timeout_o` = 1 and `connect_o` = 0. It takes at least `POLL_MAX*CLK_PER_US` cycles.
- R5: In the main profile, a power-down with mode 3 clears `connect_o`, then clears `suspm_o` on the next cycle, then sets `pll_rst_o` on the cycle after that.
- R6: In the main profile, a command with any mode other than 3 only pulses `done_o` and leaves all three control outputs unchanged.
- R7: In the alternate profile, a power-up clears `pll_rst_o` and then waits `SETTLE_US` ticks (at least `SETTLE_US*CLK_PER_US` cycles). After the wait it sets `suspm_o` only when the mode is 2. It never sets `connect_o`, whatever the lock input does.
- R8: In the alternate profile, a power-down clears `suspm_o` when the mode is 2 and then sets `pll_rst_o`. For any other mode it only sets `pll_rst_o`.
- R9: `busy_o` is high from the cycle after a command is accepted until `done_o` has pulsed. A command that arrives while `busy_o` is high is dropped and has no effect. `done_o` lasts one cycle.
- R10: If power-up and power-down are requested in the same idle cycle, power-up wins. `timeout_o` is cleared when the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on_req_i | input | 1 | Power-up command, sampled when idle |
| pwr_off_req_i | input | 1 | Power-down command, sampled when idle |
| mode_sel_i | input | 2 | PHY mode: 3 = high-speed function, 2 = high-speed USB 2.0 |
| pll_lock_i | input | 1 | PLL lock status from the PHY |
| pll_rst_o | output | 1 | PLL reset control |
| suspm_o | output | 1 | Suspend-mode control |
| connect_o | output | 1 | Connect control |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when a sequence ends |
| timeout_o | output | 1 | Last power-up found no lock |

## Verification
The assertions assume that `pll_lock_i` is low only while the PLL is held in reset or still settling, and that it does not glitch between polls. The bench lock model follows this: it raises lock a set number of cycles after `pll_rst_o` falls and drops it as soon as reset is applied again. They also assume that `mode_sel_i` only matters at the cycle a command is accepted. The bench changes it only between sequences, and it sends its overlapping commands only to test that they are dropped.

// File: rtl/usbphy_pwr_pkg.sv
package usbphy_pwr_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST_LO,
    ST_SETTLE,
    ST_SUSP_HI,
    ST_POLL,
    ST_CONN_LO,
    ST_SUSP_LO,
    ST_RST_HI,
    ST_DONE
  } seq_st_e;

  localparam logic [1:0] MODE_HS_FUNC = 2'd3;
  localparam logic [1:0] MODE_HS_20   = 2'd2;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Clock cycles spanned by a number of microsecond ticks
  function automatic int unsigned us_to_cycles(input int unsigned us, input int unsigned per_us);
    return us * per_us;
  endfunction

  // Whether a command with this mode runs any register steps
  function automatic logic mode_active(input logic alt, input logic [1:0] mode);
    return alt ? 1'b1 : (mode == MODE_HS_FUNC);
  endfunction

endpackage

// File: rtl/usbphy_tick_gen.sv
module usbphy_tick_gen #(
  parameter int unsigned CLK_PER_US = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int unsigned DW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [DW-1:0] LAST = DW'(CLK_PER_US - 1);

  logic [DW-1:0] div_q;
  logic          wrap;

  assign wrap = (div_q == LAST);
  assign tick = wrap && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (clr)    div_q <= '0;
    else if (wrap)   div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    div_q <= LAST); // R4
endmodule

// File: rtl/usbphy_wait_ctr.sv
module usbphy_wait_ctr #(
  parameter int unsigned CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] limit,
  output logic          last
);
  logic [CW-1:0] cnt_q;

  assign last = (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr)            cnt_q <= '0;
    else if (inc && !last)   cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && last) |=> (cnt_q <= $past(cnt_q))); // R4
endmodule

// File: rtl/usbphy_seq_fsm.sv
module usbphy_seq_fsm
  import usbphy_pwr_pkg::*;
#(
  parameter bit          ALT_PROFILE = 1'b0,
  parameter int unsigned POLL_MAX    = 20,
  parameter int unsigned SETTLE_US   = 340,
  parameter int unsigned CW          = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          on_req,
  input  logic          off_req,
  input  logic [1:0]    mode_sel,
  input  logic          pll_lock,
  input  logic          tick,
  input  logic          cnt_last,
  output logic          wait_clr,
  output logic [CW-1:0] cnt_limit,
  output logic          pll_rst_o,
  output logic          suspm_o,
  output logic          connect_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          timeout_o
);
  seq_st_e    st_q;
  logic [1:0] mode_q;
  logic       in_wait;
  logic       accept;
  logic       lock_hit;
  logic       poll_expire;

  assign in_wait     = (st_q == ST_POLL) || (st_q == ST_SETTLE);
  assign wait_clr    = !in_wait;
  assign cnt_limit   = (st_q == ST_SETTLE) ? CW'(SETTLE_US - 1) : CW'(POLL_MAX - 1);
  assign accept      = (st_q == ST_IDLE) && (on_req || off_req);
  assign lock_hit    = (st_q == ST_POLL) && tick && pll_lock;
  assign poll_expire = (st_q == ST_POLL) && tick && !pll_lock && cnt_last;
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = (st_q == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      mode_q    <= '0;
      pll_rst_o <= 1'b1;
      suspm_o   <= 1'b0;
      connect_o <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (on_req) begin
            mode_q    <= mode_sel;
            timeout_o <= 1'b0;
            st_q      <= mode_active(ALT_PROFILE, mode_sel) ? ST_RST_LO : ST_DONE;
          end else if (off_req) begin
            mode_q    <= mode_sel;
            timeout_o <= 1'b0;
            if (ALT_PROFILE)
              st_q <= (mode_sel == MODE_HS_20) ? ST_SUSP_LO : ST_RST_HI;
            else
              st_q <= (mode_sel == MODE_HS_FUNC) ? ST_CONN_LO : ST_DONE;
          end
        end
        ST_RST_LO: begin
          pll_rst_o <= 1'b0;
          st_q      <= ALT_PROFILE ? ST_SETTLE : ST_SUSP_HI;
        end
        ST_SETTLE: begin
          if (tick && cnt_last)
            st_q <= (mode_q == MODE_HS_20) ? ST_SUSP_HI : ST_DONE;
        end
        ST_SUSP_HI: begin
          suspm_o <= 1'b1;
          st_q    <= ALT_PROFILE ? ST_DONE : ST_POLL;
        end
        ST_POLL: begin
          if (lock_hit) begin
            connect_o <= 1'b1;
            st_q      <= ST_DONE;
          end else if (poll_expire) begin
            timeout_o <= 1'b1;
            st_q      <= ST_DONE;
          end
        end
        ST_CONN_LO: begin
          connect_o <= 1'b0;
          st_q      <= ST_SUSP_LO;
        end
        ST_SUSP_LO: begin
          suspm_o <= 1'b0;
          st_q    <= ST_RST_HI;
        end
        ST_RST_HI: begin
          pll_rst_o <= 1'b1;
          st_q      <= ST_DONE;
        end
        ST_DONE:  st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  AST_CONN_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(connect_o) |-> $past(pll_lock)); // R3
  AST_CONN_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    connect_o |-> (suspm_o && !pll_rst_o)); // R2
  AST_SUSP_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspm_o) |-> ($past(!pll_rst_o) && !pll_rst_o)); // R2
  AST_TIMEOUT_NO_CONN: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> !connect_o); // R4
  AST_ALT_NO_CONN: assert property (@(posedge clk) disable iff (!rst_n)
    (ALT_PROFILE == 1'b0) || !connect_o); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !on_req && !off_req) |=>
      ($stable(pll_rst_o) && $stable(suspm_o) && $stable(connect_o))); // R9
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o); // R9
  AST_ON_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && on_req && off_req && mode_active(ALT_PROFILE, mode_sel)) |=> !pll_rst_o || (st_q == ST_RST_LO)); // R10
endmodule

// File: rtl/usbphy_pwr_seq.sv
module usbphy_pwr_seq
  import usbphy_pwr_pkg::*;
#(
  parameter int unsigned CLK_PER_US  = 8,
  parameter int unsigned POLL_MAX    = 20,
  parameter int unsigned SETTLE_US   = 340,
  parameter bit          ALT_PROFILE = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_on_req_i,
  input  logic       pwr_off_req_i,
  input  logic [1:0] mode_sel_i,
  input  logic       pll_lock_i,
  output logic       pll_rst_o,
  output logic       suspm_o,
  output logic       connect_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       timeout_o
);
  localparam int unsigned CW = $clog2(max_u(POLL_MAX, SETTLE_US) + 1);

  logic          us_tick;
  logic          wait_clr;
  logic          cnt_last;
  logic [CW-1:0] cnt_limit;

  usbphy_tick_gen #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (wait_clr),
    .tick  (us_tick)
  );

  usbphy_wait_ctr #(.CW(CW)) u_wait (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (wait_clr),
    .inc   (us_tick),
    .limit (cnt_limit),
    .last  (cnt_last)
  );

  usbphy_seq_fsm #(
    .ALT_PROFILE (ALT_PROFILE),
    .POLL_MAX    (POLL_MAX),
    .SETTLE_US   (SETTLE_US),
    .CW          (CW)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .on_req    (pwr_on_req_i),
    .off_req   (pwr_off_req_i),
    .mode_sel  (mode_sel_i),
    .pll_lock  (pll_lock_i),
    .tick      (us_tick),
    .cnt_last  (cnt_last),
    .wait_clr  (wait_clr),
    .cnt_limit (cnt_limit),
    .pll_rst_o (pll_rst_o),
    .suspm_o   (suspm_o),
    .connect_o (connect_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .timeout_o (timeout_o)
  );
endmodule

// File: tb/usbphy_pwr_seq_tb.sv
`timescale 1ns/1ps
module usbphy_pwr_seq_tb;
  localparam int K    = 4;
  localparam int NPOL = 20;
  localparam int SETL = 340;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // main-profile DUT
  logic on_m = 0, off_m = 0, lock_m;
  logic [1:0] mode_m = 2'd3;
  logic rst_m, sus_m, con_m, busy_m, done_m, to_m;
  // alternate-profile DUT
  logic on_a = 0, off_a = 0;
  logic [1:0] mode_a = 2'd2;
  logic rst_a, sus_a, con_a, busy_a, done_a, to_a;

  usbphy_pwr_seq #(.CLK_PER_US(K), .POLL_MAX(NPOL), .SETTLE_US(SETL), .ALT_PROFILE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_on_req_i(on_m), .pwr_off_req_i(off_m), .mode_sel_i(mode_m),
    .pll_lock_i(lock_m), .pll_rst_o(rst_m), .suspm_o(sus_m), .connect_o(con_m),
    .busy_o(busy_m), .done_o(done_m), .timeout_o(to_m));

  usbphy_pwr_seq #(.CLK_PER_US(K), .POLL_MAX(NPOL), .SETTLE_US(SETL), .ALT_PROFILE(1'b1)) u_dut_alt (
    .clk(clk), .rst_n(rst_n), .pwr_on_req_i(on_a), .pwr_off_req_i(off_a), .mode_sel_i(mode_a),
    .pll_lock_i(1'b1), .pll_rst_o(rst_a), .suspm_o(sus_a), .connect_o(con_a),
    .busy_o(busy_a), .done_o(done_a), .timeout_o(to_a));

  // PLL lock model: rises lock_delay cycles after reset is released
  int lock_delay = 30;
  int lock_cnt = 0;
  always_ff @(posedge clk) begin
    if (rst_m) begin lock_cnt <= 0; lock_m <= 1'b0; end
    else begin lock_cnt <= lock_cnt + 1; lock_m <= (lock_cnt >= lock_delay); end
  end

  // edge timestamp monitor on the main DUT
  int t_rst_fall, t_rst_rise, t_sus_rise, t_sus_fall, t_con_rise, t_con_fall;
  logic p_rst = 1, p_sus = 0, p_con = 0;
  always @(negedge clk) begin
    if (p_rst && !rst_m) t_rst_fall = cyc;
    if (!p_rst && rst_m) t_rst_rise = cyc;
    if (!p_sus && sus_m) t_sus_rise = cyc;
    if (p_sus && !sus_m) t_sus_fall = cyc;
    if (!p_con && con_m) t_con_rise = cyc;
    if (p_con && !con_m) t_con_fall = cyc;
    p_rst = rst_m; p_sus = sus_m; p_con = con_m;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pulse a command and wait for done; returns elapsed cycles
  task automatic run_main(input bit on, input bit off, input logic [1:0] m, output int el);
    int t0;
    @(negedge clk);
    mode_m = m; on_m = on; off_m = off; t0 = cyc;
    @(negedge clk);
    on_m = 0; off_m = 0;
    chk(busy_m == 1'b1, "R9 busy after accept", busy_m, 1);
    for (int i = 0; i < 5000 && !done_m; i++) @(negedge clk);
    el = cyc - t0;
    chk(done_m == 1'b1, "R9 done seen", done_m, 1);
    @(negedge clk);
    chk(done_m == 1'b0 && busy_m == 1'b0, "R9 done one cycle", done_m, 0);
  endtask

  task automatic run_alt(input bit on, input logic [1:0] m, output int el);
    int t0;
    @(negedge clk);
    mode_a = m; on_a = on; off_a = !on; t0 = cyc;
    @(negedge clk);
    on_a = 0; off_a = 0;
    for (int i = 0; i < 5000 && !done_a; i++) @(negedge clk);
    el = cyc - t0;
    chk(done_a == 1'b1, "R7 alt done seen", done_a, 1);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(rst_m == 1 && sus_m == 0 && con_m == 0, "R1 main controls", {rst_m, sus_m, con_m}, 3'b100);
    chk(busy_m == 0 && done_m == 0 && to_m == 0, "R1 main status", {busy_m, done_m, to_m}, 0);
    chk(rst_a == 1 && sus_a == 0 && con_a == 0, "R1 alt controls", {rst_a, sus_a, con_a}, 3'b100);
  endtask

  task automatic t_on_lock();
    int el;
    lock_delay = 30;
    run_main(1, 0, 2'd3, el);
    chk(rst_m == 0 && sus_m == 1 && con_m == 1, "R3 powered", {rst_m, sus_m, con_m}, 3'b011);
    chk(to_m == 0, "R3 no timeout", to_m, 0);
    chk(t_sus_rise > t_rst_fall, "R2 suspend after reset release", t_sus_rise, t_rst_fall + 1);
    chk(t_con_rise > t_sus_rise, "R2 connect after suspend", t_con_rise, t_sus_rise + 1);
  endtask

  task automatic t_off_main();
    int el;
    run_main(0, 1, 2'd3, el);
    chk(rst_m == 1 && sus_m == 0 && con_m == 0, "R5 powered down", {rst_m, sus_m, con_m}, 3'b100);
    chk(t_sus_fall == t_con_fall + 1, "R5 suspend clears next cycle", t_sus_fall - t_con_fall, 1);
    chk(t_rst_rise == t_sus_fall + 1, "R5 reset sets next cycle", t_rst_rise - t_sus_fall, 1);
  endtask

  task automatic t_timeout();
    int el;
    lock_delay = 100000;
    run_main(1, 0, 2'd3, el);
    chk(to_m == 1 && con_m == 0, "R4 timeout no connect", {to_m, con_m}, 2'b10);
    chk(el >= NPOL * K && el <= NPOL * K + 8, "R4 poll window", el, NPOL * K);
    run_main(0, 1, 2'd3, el);
    chk(to_m == 0, "R10 timeout cleared by next command", to_m, 0);
    lock_delay = 30;
  endtask

  task automatic t_skip();
    int el;
    for (int m = 0; m < 3; m++) begin
      run_main(1, 0, 2'(m), el);
      chk(rst_m == 1 && sus_m == 0 && con_m == 0, "R6 on skipped", {rst_m, sus_m, con_m}, 3'b100);
      chk(el <= 3, "R6 immediate done", el, 2);
    end
  endtask

  task automatic t_busy_drop();
    int el;
    // off request during an on sequence must be dropped
    @(negedge clk); mode_m = 2'd3; on_m = 1;
    @(negedge clk); on_m = 0;
    @(negedge clk); off_m = 1;
    @(negedge clk); off_m = 0;
    for (int i = 0; i < 5000 && !done_m; i++) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(con_m == 1 && busy_m == 0, "R9 overlapping off dropped", {con_m, busy_m}, 2'b10);
    run_main(0, 1, 2'd3, el);
  endtask

  task automatic t_both();
    int el;
    run_main(1, 1, 2'd3, el);
    chk(con_m == 1 && rst_m == 0, "R10 on wins", {con_m, rst_m}, 2'b10);
    run_main(0, 1, 2'd3, el);
  endtask

  task automatic t_alt();
    int el;
    run_alt(1, 2'd2, el);
    chk(rst_a == 0 && sus_a == 1 && con_a == 0, "R7 alt on mode2", {rst_a, sus_a, con_a}, 3'b010);
    chk(el >= SETL * K && el <= SETL * K + 8, "R7 settle delay", el, SETL * K);
    run_alt(0, 2'd2, el);
    chk(rst_a == 1 && sus_a == 0, "R8 alt off mode2", {rst_a, sus_a}, 2'b10);
    run_alt(1, 2'd1, el);
    chk(rst_a == 0 && sus_a == 0 && con_a == 0, "R7 alt on other mode", {rst_a, sus_a, con_a}, 3'b000);
    run_alt(0, 2'd1, el);
    chk(rst_a == 1 && sus_a == 0, "R8 alt off other mode", {rst_a, sus_a}, 2'b10);
  endtask

  bit finished = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_on_lock();
    t_off_main();
    t_timeout();
    t_skip();
    t_busy_drop();
    t_both();
    t_alt();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule